// File: doc/BRIEF.md
# PHY Interrupt Register Bank

A byte-wide register bank for the control side of a USB PHY. It keeps a falling-edge interrupt enable and a scratch byte. It also reports the live host-disconnect level, a sticky event byte that is emptied by reading it, and the two line-state bits. The block samples the host-disconnect input every clock. When host mode is on and the enable allows it, a high-to-low change of that input is recorded in the event byte. The interrupt output is raised while that byte holds any 1.

Each writable byte answers at three consecutive addresses: a plain load, an OR of the written ones, and an AND-NOT of the written ones. Any of the three addresses reads the stored value. Read data is combinational from the address. A read's side effect, clearing the event byte, takes place at the clock edge on which `rd_en` is high.

Top module: `phy_irq_regs`

## Requirements
- R1: After reset the enable byte reads 0x01, the scratch byte reads 0x00, the event byte reads 0x00 and `irq` is low.
- R2: A write to 0x10 loads the enable byte, a write to 0x11 ORs `wdata` into it, and a write to 0x12 clears the bits that are 1 in `wdata`; reads of 0x10, 0x11 and 0x12 all return it.
- R3: The scratch byte uses the same load/OR/clear scheme at 0x16, 0x17 and 0x18, reads at all three, and has no effect on any other register or output.
- R4: A read of 0x13 returns `host_disc` in bit 0 and 0 in bits 7:1.
- R5: Event bit 0 (address 0x14) becomes 1 at the clock edge where `host_disc` is 0, its value sampled at the previous edge was 1, `host_mode` is 1 and enable bit 0 is 1.
- R6: A read of 0x14 returns the event byte, and at that clock edge the byte is cleared.
- R7: When a read of 0x14 and a qualifying falling edge occur at the same edge, event bit 0 remains 1.
- R8: No event is recorded while `host_mode` is 0 or enable bit 0 is 0, whatever the other enable bits hold.
- R9: A read of 0x15 returns `line_state[1:0]` in bits 1:0 and 0 in bits 7:2.
- R10: `irq` is 1 exactly when the event byte is nonzero.
- R11: Reads of any address outside 0x10 to 0x18 return 0x00. Writes to 0x13, 0x14, 0x15 or any unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe; enables the clear-on-read side effect |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| host_mode | input | 1 | High when the PHY acts as host |
| host_disc | input | 1 | Host-disconnect level |
| line_state | input | 2 | Current line-state bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is driven to a known value once reset is released. They also assume that `host_disc` is synchronous to `clk`, so that one sampled edge is one transition. The bench drives all inputs on the falling clock edge from values it always sets, and it holds them steady through the rising edge. Random phases also toggle `host_disc`, `host_mode` and the enable, and issue reads of 0x14, so that edges, masked edges and read collisions all occur together.

// File: rtl/phy_irq_regs.sv
module phy_irq_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] EN_BASE  = 8'h10,
  parameter logic [AW-1:0] ST_ADDR  = 8'h13,
  parameter logic [AW-1:0] LAT_ADDR = 8'h14,
  parameter logic [AW-1:0] DBG_ADDR = 8'h15,
  parameter logic [AW-1:0] SCR_BASE = 8'h16,
  parameter logic [DW-1:0] EN_RST   = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          host_mode,
  input  logic          host_disc,
  input  logic [1:0]    line_state,
  output logic          irq
);
  localparam logic [AW-1:0] NALIAS = 3;

  logic [DW-1:0] en_q, scr_q, lat_q;
  logic          disc_q;
  logic [AW-1:0] en_off, scr_off;
  logic          en_hit, scr_hit, evt, rd_clr;

  assign en_off  = addr - EN_BASE;
  assign scr_off = addr - SCR_BASE;
  assign en_hit  = en_off < NALIAS;
  assign scr_hit = scr_off < NALIAS;
  assign evt     = host_mode & en_q[0] & disc_q & ~host_disc;
  assign rd_clr  = rd_en & (addr == LAT_ADDR);
  assign irq     = |lat_q;

  function automatic logic [DW-1:0] alias_upd(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] wd,
                                              input logic [AW-1:0] off);
    case (off)
      0:       return wd;
      1:       return cur | wd;
      2:       return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      scr_q  <= '0;
      lat_q  <= '0;
      disc_q <= 1'b0;
    end else begin
      disc_q <= host_disc;
      if (wr_en && en_hit)  en_q  <= alias_upd(en_q, wdata, en_off);
      if (wr_en && scr_hit) scr_q <= alias_upd(scr_q, wdata, scr_off);
      if (rd_clr) lat_q <= {{(DW-1){1'b0}}, evt};
      else        lat_q <= lat_q | {{(DW-1){1'b0}}, evt};
    end
  end

  always_comb begin
    rdata = '0;
    if (en_hit)                 rdata = en_q;
    else if (scr_hit)           rdata = scr_q;
    else if (addr == ST_ADDR)   rdata = {{(DW-1){1'b0}}, host_disc};
    else if (addr == LAT_ADDR)  rdata = lat_q;
    else if (addr == DBG_ADDR)  rdata = {{(DW-2){1'b0}}, line_state};
  end
endmodule

// File: rtl/phy_irq_regs_chk.sv
module phy_irq_regs_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] EN_BASE  = 8'h10,
  parameter logic [AW-1:0] LAT_ADDR = 8'h14,
  parameter logic [AW-1:0] DBG_ADDR = 8'h15,
  parameter logic [AW-1:0] SCR_BASE = 8'h16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          host_mode,
  input logic          host_disc,
  input logic [1:0]    line_state,
  input logic          irq,
  input logic [DW-1:0] en_q,
  input logic [DW-1:0] scr_q,
  input logic [DW-1:0] lat_q,
  input logic          disc_q
);
  logic [AW-1:0] en_off, scr_off;
  assign en_off  = addr - EN_BASE;
  assign scr_off = addr - SCR_BASE;

  a_r5_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && en_q[0] && disc_q && !host_disc) |=> (lat_q[0] && irq));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == LAT_ADDR && !(host_mode && en_q[0] && disc_q && !host_disc)) |=> !irq);

  a_r8_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_q[0] && (!host_mode || !en_q[0])) |=> !lat_q[0]);

  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en_off == 1) |=> en_q == ($past(en_q) | $past(wdata)));

  a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && scr_off == 2) |=> scr_q == ($past(scr_q) & ~$past(wdata)));

  a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en_off > 2 && scr_off > 2) |=> ($stable(en_q) && $stable(scr_q)));

  a_r9_debug_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DBG_ADDR) |-> rdata == {{(DW-2){1'b0}}, line_state});
endmodule

bind phy_irq_regs phy_irq_regs_chk #(
  .AW(AW), .DW(DW), .EN_BASE(EN_BASE), .LAT_ADDR(LAT_ADDR),
  .DBG_ADDR(DBG_ADDR), .SCR_BASE(SCR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .host_mode(host_mode), .host_disc(host_disc),
  .line_state(line_state), .irq(irq), .en_q(en_q), .scr_q(scr_q),
  .lat_q(lat_q), .disc_q(disc_q)
);

// File: tb/sim_phy_irq_regs.sv
module sim_phy_irq_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, host_mode = 0, host_disc = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [1:0] line_state = 0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] m_en = 8'h01, m_scr = 8'h00, m_lat = 8'h00;
  logic m_prev = 1'b0;

  always #10 clk = ~clk;

  phy_irq_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .host_mode(host_mode),
    .host_disc(host_disc), .line_state(line_state), .irq(irq));

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h12) return m_en;
    if (a >= 8'h16 && a <= 8'h18) return m_scr;
    if (a == 8'h13) return {7'b0, host_disc};
    if (a == 8'h14) return m_lat;
    if (a == 8'h15) return {6'b0, line_state};
    return 8'h00;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a >= 8'h10 && a <= 8'h12) return "R2";
    if (a >= 8'h16 && a <= 8'h18) return "R3";
    if (a == 8'h13) return "R4";
    if (a == 8'h14) return "R6";
    if (a == 8'h15) return "R9";
    return "R11";
  endfunction

  function automatic logic [7:0] upd(input logic [7:0] cur, wd, input int off);
    case (off)
      0: return wd;
      1: return cur | wd;
      2: return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic we, input logic re,
                      input logic [7:0] a, input logic [7:0] wd,
                      input logic disc, input logic mode);
    logic evt;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = wd;
    host_disc = disc; host_mode = mode; line_state = 2'($urandom);
    #1;
    chk(tg == "" ? req_of(a) : tg, rdata, exp_rd(a));
    chk("R10", {7'b0, irq}, {7'b0, |m_lat});
    @(posedge clk);
    evt = m_prev & ~disc & mode & m_en[0];
    if (re && a == 8'h14) m_lat = {7'b0, evt};
    else m_lat = m_lat | {7'b0, evt};
    if (we && a >= 8'h10 && a <= 8'h12) m_en = upd(m_en, wd, int'(a - 8'h10));
    if (we && a >= 8'h16 && a <= 8'h18) m_scr = upd(m_scr, wd, int'(a - 8'h16));
    m_prev = disc;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1310));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    step("R1", 0, 0, 8'h10, 0, 0, 1);
    step("R1", 0, 0, 8'h16, 0, 0, 1);
    step("R1", 0, 0, 8'h14, 0, 0, 1);
    // R2 aliases
    step("", 1, 0, 8'h10, 8'hA5, 0, 1);
    step("", 0, 0, 8'h11, 0, 0, 1);
    step("", 1, 0, 8'h11, 8'h0A, 0, 1);
    step("", 1, 0, 8'h12, 8'h05, 0, 1);
    step("", 0, 0, 8'h12, 0, 0, 1);
    step("", 1, 0, 8'h10, 8'h01, 0, 1);
    // R3 scratch
    step("", 1, 0, 8'h16, 8'h3C, 0, 1);
    step("", 1, 0, 8'h17, 8'h81, 0, 1);
    step("", 1, 0, 8'h18, 8'h0C, 0, 1);
    step("", 0, 0, 8'h17, 0, 0, 1);
    // R5 fall, R6 read clear
    step("R4", 0, 0, 8'h13, 0, 1, 1);
    step("R5", 0, 0, 8'h13, 0, 0, 1);
    step("R5", 0, 1, 8'h14, 0, 0, 1);
    step("R6", 0, 0, 8'h14, 0, 0, 1);
    // R7 collision
    step("", 0, 0, 8'h14, 0, 1, 1);
    step("R7", 0, 1, 8'h14, 0, 0, 1);
    step("R7", 0, 1, 8'h14, 0, 0, 1);
    step("R6", 0, 0, 8'h14, 0, 0, 1);
    // R8 masked by mode, then by enable
    step("", 0, 0, 8'h14, 0, 1, 0);
    step("R8", 0, 0, 8'h14, 0, 0, 0);
    step("R8", 1, 0, 8'h12, 8'h01, 1, 1);
    step("R8", 1, 0, 8'h11, 8'hFE, 0, 1);
    step("R8", 0, 0, 8'h14, 0, 0, 1);
    step("", 1, 0, 8'h10, 8'h01, 0, 1);
    // R11 ignored writes and unmapped reads
    step("R11", 1, 0, 8'h13, 8'hFF, 0, 1);
    step("R11", 1, 0, 8'h14, 8'hFF, 0, 1);
    step("R11", 1, 0, 8'h15, 8'hFF, 0, 1);
    step("R11", 1, 0, 8'h0F, 8'hFF, 0, 1);
    step("R11", 1, 0, 8'h19, 8'hFF, 0, 1);
    step("R11", 0, 0, 8'h10, 0, 0, 1);
    step("R11", 0, 0, 8'h16, 0, 0, 1);
    step("R9", 0, 0, 8'h15, 0, 0, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = 8'h0E + 8'($urandom_range(0, 12));
      step("", ($urandom % 4) == 0, ($urandom % 3) == 0, a, 8'($urandom),
           1'($urandom), ($urandom % 5) != 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule